// File: doc/BRIEF.md
# Memory Client Statistics Gatherer

This block is a performance-monitoring unit inside a memory controller. It has two independent event counters, called lanes, and one sample-clock counter that both lanes share. Software sets up each lane with an event kind, an optional filter on the requesting client's ID and an optional filter on one of the three arbitration priority signals. It then starts a sampling window and later stops it. It reads back both event counts and the number of memory-clock cycles that elapsed. Turning the counts into percentages happens in software.

Each cycle the block watches a request-event bus. The bus carries a grant strobe, the winning client's ID, the direction (read or write), the high-priority, timeout and bandwidth arbitration signals, and flags for page miss, auto-precharge and the two bank-arbitration conditions. The block keeps the previous grant's client and direction so that it can detect a change of direction and a repeated winner. The clock counter stops at a programmable limit, and both lanes stop with it.

Top module: `mem_client_stat`

## Requirements
- R1: After reset, the elapsed-clock count, both lane counts and both lane configurations read as zero, and the clock limit reads as all ones.
- R2: Registers are at word index 0 (command, write only, reads zero), 1 (clock limit), 2 (elapsed clocks, read only), 3 and 4 (lane 0 and lane 1 configuration), and 5 and 6 (lane 0 and lane 1 count). A configuration word holds the client ID in bits 13:8, the event kind in bits 23:16, the priority-signal select in bits 25:24, the client-filter enable in bit 26 and the priority-filter mode in bits 29:28. Other bits read back as zero.
- R3: With the client and priority filters off, event kind 0 counts every grant, 1 counts read grants, 2 counts write grants, 5 and 6 count grants that carry the bank-A or bank-B arbitration flag, 7 counts grants flagged as page miss and 8 counts grants flagged as auto-precharge. A count rises by at most one per cycle.
- R4: Event kind 3 counts a grant whose direction differs from the previous counted grant's direction. Idle cycles do not reset the previous grant.
- R5: Event kind 4 counts a grant whose client equals the previous counted grant's client, so N consecutive grants to one client add N-1. The first grant after a clear or reset adds nothing.
- R6: When bit 26 is set, a lane counts only grants whose client ID equals bits 13:8. When bit 26 is clear, grants from every client are counted.
- R7: The priority select picks 0 high-priority, 1 timeout or 2 bandwidth. Filter mode 1 counts only when the selected signal is low, mode 2 only when it is high, and modes 0 and 3 do not filter.
- R8: Command code 3 in bits 9:8 starts counting and code 2 freezes it. The cycle on whose edge the freeze is written is still counted. While frozen, the counters hold their values and grants have no effect.
- R9: Command code 1 zeroes the elapsed-clock count, both lane counts and the grant history, and it leaves the run state as it was.
- R10: Command code 0 zeroes the counts and the grant history and stops counting.
- R11: The elapsed-clock count advances once per running cycle while it is below the clock limit. Once it reaches the limit, the clock counter and both lanes stop, and the lane counts never exceed the clock count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register word index for writes |
| wrData | input | 32 | Register write data |
| rdAddr | input | 3 | Register word index for reads |
| rdData | output | 32 | Read data, combinational from rdAddr |
| evValid | input | 1 | A request was granted this cycle |
| evClient | input | 6 | ID of the granted client |
| evWrite | input | 1 | Granted request is a write (1) or read (0) |
| evHp | input | 1 | High-priority arbitration signal |
| evTm | input | 1 | Timeout arbitration signal |
| evBw | input | 1 | Bandwidth arbitration signal |
| evPageMiss | input | 1 | Granted request missed the open page |
| evAutoPre | input | 1 | Granted request uses auto-precharge |
| evBankA | input | 1 | Bank-A arbitration condition |
| evBankB | input | 1 | Bank-B arbitration condition |

## Verification
The bench targets the grant history. A design that does not clear it on clear or reset credits a phantom repeat to the first grant of a new window. A design that drops it during idle cycles misses repeat and direction-change events across gaps. The bench also probes the freeze edge and the clock limit. A design that stops one cycle early, or that lets lanes keep counting after the clock saturates, returns an elapsed count or an event count that is off by one or more. Finally, it drives grants while counting is frozen and drives non-matching clients and priority levels, which catches filters that leak or counters that are not truly held.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  localparam int CLIENT_W   = 6;
  localparam int NUM_GATHER = 2;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 32;

  localparam int REG_CMD   = 0;
  localparam int REG_LIMIT = 1;
  localparam int REG_CLK   = 2;
  localparam int REG_CFG0  = 3;
  localparam int REG_CNT0  = 5;

  typedef enum logic [1:0] {
    CMD_RESET  = 2'd0,
    CMD_CLEAR  = 2'd1,
    CMD_FREEZE = 2'd2,
    CMD_RUN    = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [CLIENT_W-1:0] client;
    logic [7:0]          evSel;
    logic [1:0]          prioSel;
    logic                clientEn;
    logic [1:0]          prioMode;
  } gcfg_t;

  typedef struct packed {
    logic run;
    logic wipe;
  } strobe_t;

  typedef struct packed {
    logic                valid;
    logic [CLIENT_W-1:0] client;
    logic                isWrite;
    logic                hp;
    logic                tm;
    logic                bw;
    logic                pageMiss;
    logic                autoPre;
    logic                bankA;
    logic                bankB;
  } reqev_t;

  function automatic gcfg_t unpackCfg(logic [DATA_W-1:0] w);
    gcfg_t c;
    c.client   = w[13:8];
    c.evSel    = w[23:16];
    c.prioSel  = w[25:24];
    c.clientEn = w[26];
    c.prioMode = w[29:28];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] packCfg(gcfg_t c);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[13:8]  = c.client;
    w[23:16] = c.evSel;
    w[25:24] = c.prioSel;
    w[26]    = c.clientEn;
    w[29:28] = c.prioMode;
    return w;
  endfunction
endpackage

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [DATA_W-1:0]             wrData,
  output strobe_t                       ctl,
  output gcfg_t [NUM_GATHER-1:0]        cfg,
  output logic  [CNT_W-1:0]             limit
);
  logic cmdWr;
  cmd_e cmd;
  logic runQ;

  assign cmdWr = wrEn && (wrAddr == ADDR_W'(REG_CMD));
  assign cmd   = cmd_e'(wrData[9:8]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0;
    end else if (cmdWr) begin
      case (cmd)
        CMD_RESET, CMD_FREEZE: runQ <= 1'b0;
        CMD_RUN:               runQ <= 1'b1;
        default:               runQ <= runQ;
      endcase
    end
  end

  assign ctl.run  = runQ;
  assign ctl.wipe = cmdWr && (cmd == CMD_RESET || cmd == CMD_CLEAR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limit <= '1;
    end else if (wrEn && wrAddr == ADDR_W'(REG_LIMIT)) begin
      limit <= wrData[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (wrEn) begin
      for (int g = 0; g < NUM_GATHER; g++) begin
        if (wrAddr == ADDR_W'(REG_CFG0 + g)) cfg[g] <= unpackCfg(wrData);
      end
    end
  end

  // R8
  run_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runQ) |-> $past(cmdWr && wrData[9:8] == 2'd3));

  // R10
  reset_stops_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && wrData[9:8] == 2'd0) |=> !runQ);
endmodule

// File: rtl/mcs_lane.sv
module mcs_lane
  import mcs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wipe,
  input  logic             live,
  input  gcfg_t            cfg,
  input  reqev_t           ev,
  input  logic             turn,
  input  logic             repeatWin,
  output logic [CNT_W-1:0] count
);
  logic prioSig, prioOk, clientOk, rawHit, hit;

  always_comb begin
    case (cfg.prioSel)
      2'd0:    prioSig = ev.hp;
      2'd1:    prioSig = ev.tm;
      2'd2:    prioSig = ev.bw;
      default: prioSig = 1'b0;
    endcase
    case (cfg.prioMode)
      2'd1:    prioOk = !prioSig;
      2'd2:    prioOk = prioSig;
      default: prioOk = 1'b1;
    endcase
    clientOk = !cfg.clientEn || (ev.client == cfg.client);
    case (cfg.evSel)
      8'd0:    rawHit = ev.valid;
      8'd1:    rawHit = ev.valid && !ev.isWrite;
      8'd2:    rawHit = ev.valid && ev.isWrite;
      8'd3:    rawHit = turn;
      8'd4:    rawHit = repeatWin;
      8'd5:    rawHit = ev.valid && ev.bankA;
      8'd6:    rawHit = ev.valid && ev.bankB;
      8'd7:    rawHit = ev.valid && ev.pageMiss;
      8'd8:    rawHit = ev.valid && ev.autoPre;
      default: rawHit = 1'b0;
    endcase
    hit = rawHit && clientOk && prioOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN || wipe) count <= '0;
    else if (live && hit) count <= count + 1'b1;
  end

  // R3
  lane_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wipe |=> (count == $past(count)) || (count == $past(count) + 1'b1));

  // R9
  lane_wipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    wipe |=> count == '0);
endmodule

// File: rtl/mcs_datapath.sv
module mcs_datapath
  import mcs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  strobe_t                             ctl,
  input  gcfg_t [NUM_GATHER-1:0]              cfg,
  input  logic  [CNT_W-1:0]                   limit,
  input  reqev_t                              ev,
  output logic  [CNT_W-1:0]                   clkCnt,
  output logic  [NUM_GATHER-1:0][CNT_W-1:0]   evCnt
);
  logic                live;
  logic                prevValid;
  logic [CLIENT_W-1:0] prevClient;
  logic                prevWrite;
  logic                turn, repeatWin;

  assign live = ctl.run && (clkCnt < limit);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.wipe) clkCnt <= '0;
    else if (live) clkCnt <= clkCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.wipe) begin
      prevValid  <= 1'b0;
      prevClient <= '0;
      prevWrite  <= 1'b0;
    end else if (live && ev.valid) begin
      prevValid  <= 1'b1;
      prevClient <= ev.client;
      prevWrite  <= ev.isWrite;
    end
  end

  assign turn      = ev.valid && prevValid && (ev.isWrite != prevWrite);
  assign repeatWin = ev.valid && prevValid && (ev.client == prevClient);

  for (genvar g = 0; g < NUM_GATHER; g++) begin : g_lane
    mcs_lane #(.CNT_W(CNT_W)) u_lane (
      .clk       (clk),
      .rstN      (rstN),
      .wipe      (ctl.wipe),
      .live      (live),
      .cfg       (cfg[g]),
      .ev        (ev),
      .turn      (turn),
      .repeatWin (repeatWin),
      .count     (evCnt[g])
    );

    // R11
    lane_under_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
      evCnt[g] <= clkCnt);
  end

  // R11
  clock_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkCnt >= limit && !ctl.wipe) |=> $stable(clkCnt));

  // R8
  clock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.run && !ctl.wipe) |=> $stable(clkCnt));
endmodule

// File: rtl/mem_client_stat.sv
module mem_client_stat
  import mcs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  logic                evValid,
  input  logic [CLIENT_W-1:0] evClient,
  input  logic                evWrite,
  input  logic                evHp,
  input  logic                evTm,
  input  logic                evBw,
  input  logic                evPageMiss,
  input  logic                evAutoPre,
  input  logic                evBankA,
  input  logic                evBankB
);
  strobe_t                            ctl;
  gcfg_t [NUM_GATHER-1:0]             cfg;
  logic  [CNT_W-1:0]                  limit;
  logic  [CNT_W-1:0]                  clkCnt;
  logic  [NUM_GATHER-1:0][CNT_W-1:0]  evCnt;
  reqev_t                             ev;

  assign ev = '{valid: evValid, client: evClient, isWrite: evWrite, hp: evHp,
                tm: evTm, bw: evBw, pageMiss: evPageMiss, autoPre: evAutoPre,
                bankA: evBankA, bankB: evBankB};

  mcs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .ctl    (ctl),
    .cfg    (cfg),
    .limit  (limit)
  );

  mcs_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .cfg    (cfg),
    .limit  (limit),
    .ev     (ev),
    .clkCnt (clkCnt),
    .evCnt  (evCnt)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(REG_LIMIT)) rdData = DATA_W'(limit);
    else if (rdAddr == ADDR_W'(REG_CLK)) rdData = DATA_W'(clkCnt);
    for (int g = 0; g < NUM_GATHER; g++) begin
      if (rdAddr == ADDR_W'(REG_CFG0 + g)) rdData = packCfg(cfg[g]);
      if (rdAddr == ADDR_W'(REG_CNT0 + g)) rdData = DATA_W'(evCnt[g]);
    end
  end
endmodule

// File: tb/mem_client_stat_bench.sv
module mem_client_stat_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [2:0]  wrAddr;
  logic [31:0] wrData;
  logic [2:0]  rdAddr;
  logic [31:0] rdData;
  logic        evValid, evWrite, evHp, evTm, evBw, evPageMiss, evAutoPre, evBankA, evBankB;
  logic [5:0]  evClient;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0]  qAddr[$];
  logic [31:0] qExp[$];
  string       qTag[$];

  always #10 clk = ~clk;

  mem_client_stat u_mem_client_stat (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evValid(evValid), .evClient(evClient),
    .evWrite(evWrite), .evHp(evHp), .evTm(evTm), .evBw(evBw),
    .evPageMiss(evPageMiss), .evAutoPre(evAutoPre), .evBankA(evBankA), .evBankB(evBankB)
  );

  function automatic logic [31:0] mkCfg(int cl, int sel, int psel, bit cen, int pmode);
    logic [31:0] w;
    w = '0;
    w[13:8]  = cl[5:0];
    w[23:16] = sel[7:0];
    w[25:24] = psel[1:0];
    w[26]    = cen;
    w[29:28] = pmode[1:0];
    return w;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cmd(input logic [1:0] c);
    wr(3'd0, {22'd0, c, 8'd0});
  endtask

  // flags: {bankB, bankA, autoPre, pageMiss, bw, tm, hp}
  task automatic grant(input int cl, input bit w, input logic [6:0] f);
    evValid = 1'b1; evClient = cl[5:0]; evWrite = w;
    {evBankB, evBankA, evAutoPre, evPageMiss, evBw, evTm, evHp} = f;
    @(negedge clk);
    evValid = 1'b0; evWrite = 1'b0;
    {evBankB, evBankA, evAutoPre, evPageMiss, evBw, evTm, evHp} = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectReg(input logic [2:0] a, input logic [31:0] e, input string tag);
    qAddr.push_back(a); qExp.push_back(e); qTag.push_back(tag);
  endtask

  task automatic settle();
    wait (qAddr.size() == 0);
  endtask

  // monitor: pops expected items and compares them with the read port
  initial begin
    rdAddr = '0;
    forever begin
      wait (qAddr.size() != 0);
      rdAddr = qAddr[0];
      #1;
      checks++;
      if (rdData !== qExp[0]) begin
        errors++;
        $display("FAIL %s: addr %0d actual 0x%08h expected 0x%08h",
                 qTag[0], qAddr[0], rdData, qExp[0]);
      end
      void'(qAddr.pop_front());
      void'(qExp.pop_front());
      void'(qTag.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    evValid = 1'b0; evClient = '0; evWrite = 1'b0;
    {evBankB, evBankA, evAutoPre, evPageMiss, evBw, evTm, evHp} = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectReg(3'd2, 32'd0, "R1 clocks");
    expectReg(3'd5, 32'd0, "R1 lane0");
    expectReg(3'd6, 32'd0, "R1 lane1");
    expectReg(3'd1, 32'hFFFF_FFFF, "R1 limit");
    settle();
    expectReg(3'd3, 32'd0, "R1 cfg0");
    expectReg(3'd4, 32'd0, "R1 cfg1");
    settle();

    // R2 field positions in the config word, command reads zero
    wr(3'd3, 32'hFFFF_FFFF);
    expectReg(3'd3, 32'h37FF_3F00, "R2 cfg fields");
    expectReg(3'd0, 32'd0, "R2 cmd reads zero");
    settle();

    // R3 qualified and read counts, R8 window length
    wr(3'd3, mkCfg(0, 0, 0, 0, 0));
    wr(3'd4, mkCfg(0, 1, 0, 0, 0));
    cmd(2'd3);
    grant(3, 0, 7'd0); grant(4, 1, 7'd0); grant(5, 0, 7'd0);
    idle(1);
    grant(3, 1, 7'd0);
    cmd(2'd2);
    expectReg(3'd2, 32'd6, "R8 clocks in window");
    expectReg(3'd5, 32'd4, "R3 qualified");
    expectReg(3'd6, 32'd2, "R3 reads");
    settle();

    // R8 grants while frozen have no effect
    grant(3, 0, 7'd0); grant(3, 1, 7'd0); idle(2);
    expectReg(3'd2, 32'd6, "R8 frozen clocks");
    expectReg(3'd5, 32'd4, "R8 frozen lane0");
    expectReg(3'd6, 32'd2, "R8 frozen lane1");
    settle();

    // R9 clear zeros counts and keeps the run state
    cmd(2'd1);
    expectReg(3'd2, 32'd0, "R9 clear clocks");
    expectReg(3'd5, 32'd0, "R9 clear lane0");
    settle();
    cmd(2'd3); idle(2); cmd(2'd1); idle(2); cmd(2'd2);
    expectReg(3'd2, 32'd3, "R9 running through clear");
    settle();

    // R4 direction change, R5 repeated winner
    cmd(2'd1);
    wr(3'd3, mkCfg(0, 3, 0, 0, 0));
    wr(3'd4, mkCfg(0, 4, 0, 0, 0));
    cmd(2'd3);
    grant(1, 0, 7'd0); grant(1, 0, 7'd0); grant(1, 1, 7'd0); grant(2, 1, 7'd0);
    idle(1);
    grant(2, 1, 7'd0); grant(2, 0, 7'd0);
    cmd(2'd2);
    expectReg(3'd5, 32'd2, "R4 direction changes");
    expectReg(3'd6, 32'd4, "R5 repeat winners");
    settle();

    // R6 client filter
    cmd(2'd1);
    wr(3'd3, mkCfg(5, 0, 0, 1, 0));
    wr(3'd4, mkCfg(5, 2, 0, 1, 0));
    cmd(2'd3);
    grant(5, 0, 7'd0); grant(6, 1, 7'd0); grant(5, 1, 7'd0); grant(5, 1, 7'd0); grant(7, 0, 7'd0);
    cmd(2'd2);
    expectReg(3'd5, 32'd3, "R6 client 5 grants");
    expectReg(3'd6, 32'd2, "R6 client 5 writes");
    settle();

    // R7 priority filter: lane0 timeout high, lane1 bandwidth low
    cmd(2'd1);
    wr(3'd3, mkCfg(0, 0, 1, 0, 2));
    wr(3'd4, mkCfg(0, 0, 2, 0, 1));
    cmd(2'd3);
    grant(1, 0, 7'b0000001); grant(1, 0, 7'b0000010); grant(1, 0, 7'b0000110);
    grant(1, 0, 7'b0000100); grant(1, 0, 7'b0000011); grant(1, 0, 7'b0000000);
    cmd(2'd2);
    expectReg(3'd5, 32'd3, "R7 timeout high");
    expectReg(3'd6, 32'd4, "R7 bandwidth low");
    settle();

    // R3 page miss and auto-precharge
    cmd(2'd1);
    wr(3'd3, mkCfg(0, 7, 0, 0, 0));
    wr(3'd4, mkCfg(0, 8, 0, 0, 0));
    cmd(2'd3);
    grant(2, 0, 7'b0001000); grant(2, 0, 7'b0010000); grant(2, 0, 7'b0011000);
    grant(2, 0, 7'b0000000); grant(2, 0, 7'b0001000);
    cmd(2'd2);
    expectReg(3'd5, 32'd3, "R3 page miss");
    expectReg(3'd6, 32'd2, "R3 auto-precharge");
    settle();

    // R3 bank arbitration flags
    cmd(2'd1);
    wr(3'd3, mkCfg(0, 5, 0, 0, 0));
    wr(3'd4, mkCfg(0, 6, 0, 0, 0));
    cmd(2'd3);
    grant(2, 0, 7'b0100000); grant(2, 0, 7'b1000000); grant(2, 0, 7'b0100000); grant(2, 0, 7'b1100000);
    cmd(2'd2);
    expectReg(3'd5, 32'd3, "R3 bank A");
    expectReg(3'd6, 32'd2, "R3 bank B");
    settle();

    // R10 reset command stops counting and clears history
    cmd(2'd1);
    wr(3'd3, mkCfg(0, 4, 0, 0, 0));
    wr(3'd4, mkCfg(0, 0, 0, 0, 0));
    cmd(2'd3);
    grant(3, 0, 7'd0); grant(3, 0, 7'd0);
    cmd(2'd0);
    idle(2);
    expectReg(3'd2, 32'd0, "R10 clocks after reset cmd");
    expectReg(3'd5, 32'd0, "R10 lane0 after reset cmd");
    expectReg(3'd6, 32'd0, "R10 lane1 after reset cmd");
    settle();
    cmd(2'd3);
    grant(3, 0, 7'd0);
    cmd(2'd2);
    expectReg(3'd5, 32'd0, "R10 history cleared");
    expectReg(3'd6, 32'd1, "R10 lane1 fresh");
    expectReg(3'd2, 32'd2, "R10 clocks fresh");
    settle();

    // R11 clock limit stops the clock and both lanes
    cmd(2'd1);
    wr(3'd1, 32'd5);
    wr(3'd3, mkCfg(0, 0, 0, 0, 0));
    cmd(2'd3);
    for (int i = 0; i < 8; i++) grant(i, 0, 7'd0);
    cmd(2'd2);
    expectReg(3'd2, 32'd5, "R11 clock saturates");
    expectReg(3'd5, 32'd5, "R11 lane stops with clock");
    expectReg(3'd1, 32'd5, "R11 limit readback");
    settle();

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule